// File: doc/BRIEF.md
# Four-Direction Matrix Parity Encoder

The block protects a 64-bit word with 46 redundant check bits. It treats the word as an 8x8 bit matrix and forms even parity over four kinds of line: every row, every column, every rising (slash) diagonal and every falling (back-slash) diagonal. A receiver that repeats the same computation can compare the four vectors against the ones it received. From the pattern of mismatching lines it can locate flipped data bits. This block only forms and registers the check bits. It does no checking and no correction.

One clock edge moves a word from the input to the registered parity outputs. A strobe marks each word to encode, and a matching flag comes out one cycle later. Between strobes the outputs keep the last result. An active-high synchronous reset clears everything. The matrix dimensions are parameters, and the diagonal count is derived from them as rows plus columns minus one.

Top module: `quad_parity_enc`

## Requirements
- R1: Byte k of `rows_in` (bits 8k+7..8k) is matrix row k, and bit j within the byte is column j. `row_par[k]` is the XOR of the 8 bits of row k.
- R2: `col_par[j]` is the XOR of bit j taken from all eight rows.
- R3: `slash_par[d]`, for d from 0 to 14, is the XOR of every cell whose row plus column equals d.
- R4: `bslash_par[d]`, for d from 0 to 14, is the XOR of every cell whose row minus column plus 7 equals d.
- R5: Every check bit is even parity. It is 1 exactly when its line holds an odd number of ones. An all-zero word therefore gives all-zero vectors. An all-ones word gives zero row and column vectors and 15'h5555 on both diagonal vectors.
- R6: When `in_valid` is sampled high, all four vectors take the new word's parity on that same edge and `out_valid` is high for the following cycle. When `in_valid` is sampled low, `out_valid` goes low.
- R7: While `in_valid` is low, changes on `rows_in` have no effect and all four vectors hold their previous values.
- R8: A high `rst` at a clock edge clears all four vectors and `out_valid` to zero, even when `in_valid` is high at the same edge.
- R9: Whenever `out_valid` is high, the XOR-reductions of the four vectors are equal to one another, since each one equals the parity of the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: encode `rows_in` at this edge |
| rows_in | input | 64 | Eight row bytes, row 0 in the low byte |
| row_par | output | 8 | Row parity, bit k for row k |
| col_par | output | 8 | Column parity, bit j for column j |
| slash_par | output | 15 | Parity of cells with row+column = d |
| bslash_par | output | 15 | Parity of cells with row-column+7 = d |
| out_valid | output | 1 | High one cycle after an accepted word |

## Verification
Reset and an encode strobe can arrive at the same edge. The bench drives an all-ones word with `in_valid` high while `rst` is also high. It then expects zero vectors and a low `out_valid` on the next cycle, with reset taking priority. A strobe can also follow directly on the previous one, so the register load and the valid flag for consecutive words share adjacent edges. The bench judges back-to-back words by checking each word's vectors exactly one cycle after it was presented, against an independent line-by-line model.

// File: rtl/quad_parity_enc.sv
module quad_parity_enc #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [ROWS*COLS-1:0]   rows_in,
  output logic [ROWS-1:0]        row_par,
  output logic [COLS-1:0]        col_par,
  output logic [ROWS+COLS-2:0]   slash_par,
  output logic [ROWS+COLS-2:0]   bslash_par,
  output logic                   out_valid
);

  localparam int NDIAG = ROWS + COLS - 1;

  logic [ROWS-1:0]  row_nxt;
  logic [COLS-1:0]  col_nxt;
  logic [NDIAG-1:0] slash_nxt;
  logic [NDIAG-1:0] bslash_nxt;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_nxt[r] = ^rows_in[r*COLS +: COLS];
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] column;
    for (genvar r = 0; r < ROWS; r++) begin : g_cell
      assign column[r] = rows_in[r*COLS + c];
    end
    assign col_nxt[c] = ^column;
  end

  always_comb begin
    slash_nxt = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        slash_nxt[r + c] = slash_nxt[r + c] ^ rows_in[r*COLS + c];
  end

  always_comb begin
    bslash_nxt = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        bslash_nxt[r - c + COLS - 1] = bslash_nxt[r - c + COLS - 1] ^ rows_in[r*COLS + c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_par    <= '0;
      col_par    <= '0;
      slash_par  <= '0;
      bslash_par <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        row_par    <= row_nxt;
        col_par    <= col_nxt;
        slash_par  <= slash_nxt;
        bslash_par <= bslash_nxt;
      end
    end
  end

endmodule

// File: rtl/quad_parity_enc_chk.sv
module quad_parity_enc_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [ROWS-1:0]      row_par,
  input logic [COLS-1:0]      col_par,
  input logic [ROWS+COLS-2:0] slash_par,
  input logic [ROWS+COLS-2:0] bslash_par,
  input logic                 out_valid
);

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(row_par) && $stable(col_par) &&
                   $stable(slash_par) && $stable(bslash_par)));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && row_par == '0 && col_par == '0 &&
                    slash_par == '0 && bslash_par == '0));

  assert_col_agrees_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^row_par == ^col_par));

  assert_slash_agrees_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^row_par == ^slash_par));

  assert_bslash_agrees_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^row_par == ^bslash_par));

endmodule

bind quad_parity_enc quad_parity_enc_chk #(.ROWS(ROWS), .COLS(COLS)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .row_par(row_par),
  .col_par(col_par), .slash_par(slash_par), .bslash_par(bslash_par),
  .out_valid(out_valid)
);

// File: tb/quad_parity_enc_test.sv
module quad_parity_enc_test;
  localparam int PERIOD = 10;
  localparam int NV = 7;

  localparam logic [63:0] STIM [NV] = '{
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0100_0000_0000_0000,
    64'h80, 64'h8000_0000_0000_0000, 64'hC1DA_3C18_9925_429D };
  localparam logic [7:0]  EXP_R [NV] = '{8'h00, 8'h00, 8'h01, 8'h80, 8'h01, 8'h80, 8'hC5};
  localparam logic [7:0]  EXP_C [NV] = '{8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h80, 8'h00};
  localparam logic [14:0] EXP_S [NV] = '{15'h0, 15'h5555, 15'h0001, 15'h0080, 15'h0080, 15'h4000, 15'h0};
  localparam logic [14:0] EXP_B [NV] = '{15'h0, 15'h5555, 15'h0080, 15'h4000, 15'h0001, 15'h0080, 15'h0};
  localparam bit          FULL  [NV] = '{1, 1, 1, 1, 1, 1, 0};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [63:0] rows_in = '0;
  logic [7:0] row_par, col_par;
  logic [14:0] slash_par, bslash_par;
  logic out_valid;
  int total = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  quad_parity_enc uut (.clk(clk), .rst(rst), .in_valid(in_valid), .rows_in(rows_in),
    .row_par(row_par), .col_par(col_par), .slash_par(slash_par),
    .bslash_par(bslash_par), .out_valid(out_valid));

  function automatic logic [7:0] m_row(logic [63:0] w);
    m_row = '0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) m_row[r] ^= w[8*r+c];
  endfunction
  function automatic logic [7:0] m_col(logic [63:0] w);
    m_col = '0;
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) m_col[c] ^= w[8*r+c];
  endfunction
  function automatic logic [14:0] m_sl(logic [63:0] w);
    m_sl = '0;
    for (int d = 0; d < 15; d++)
      for (int r = 0; r < 8; r++)
        if (d - r >= 0 && d - r < 8) m_sl[d] ^= w[8*r + d - r];
  endfunction
  function automatic logic [14:0] m_bs(logic [63:0] w);
    m_bs = '0;
    for (int d = 0; d < 15; d++)
      for (int r = 0; r < 8; r++)
        if (r + 7 - d >= 0 && r + 7 - d < 8) m_bs[d] ^= w[8*r + r + 7 - d];
  endfunction

  task automatic chk(string what, string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_check(logic [63:0] w);
    chk("row", "R1", {8'h0, row_par}, {8'h0, m_row(w)});
    chk("col", "R2", {8'h0, col_par}, {8'h0, m_col(w)});
    chk("slash", "R3", {1'b0, slash_par}, {1'b0, m_sl(w)});
    chk("bslash", "R4", {1'b0, bslash_par}, {1'b0, m_bs(w)});
    chk("xor agreement", "R9", {13'h0, ^row_par, ^slash_par, ^bslash_par},
        {13'h0, {3{^col_par}}});
  endtask

  task automatic present(logic [63:0] w);
    @(negedge clk);
    rows_in = w;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  logic [63:0] prev, w2;
  logic [7:0] held_r;
  logic [14:0] held_s;

  initial begin
    repeat (3) @(negedge clk);
    chk("out_valid in reset", "R8", {15'h0, out_valid}, 16'h0);
    chk("vectors in reset", "R8", {row_par, col_par} | {1'b0, slash_par} | {1'b0, bslash_par}, 16'h0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      present(STIM[i]);
      chk("out_valid", "R6", {15'h0, out_valid}, 16'h1);
      chk("row table", FULL[i] ? "R5" : "R1", {8'h0, row_par}, {8'h0, EXP_R[i]});
      if (FULL[i]) begin
        chk("col table", "R2", {8'h0, col_par}, {8'h0, EXP_C[i]});
        chk("slash table", "R3", {1'b0, slash_par}, {1'b0, EXP_S[i]});
        chk("bslash table", "R4", {1'b0, bslash_par}, {1'b0, EXP_B[i]});
      end else model_check(STIM[i]);
    end

    held_r = row_par; held_s = bslash_par;
    rows_in = 64'h0123_4567_89AB_CDEF;
    repeat (2) @(negedge clk);
    chk("out_valid idle", "R6", {15'h0, out_valid}, 16'h0);
    chk("row hold", "R7", {8'h0, row_par}, {8'h0, held_r});
    chk("bslash hold", "R7", {1'b0, bslash_par}, {1'b0, held_s});

    prev = 64'hDEAD_BEEF_0BAD_F00D;
    w2 = 64'h1357_9BDF_2468_ACE0;
    @(negedge clk); rows_in = prev; in_valid = 1;
    @(negedge clk); rows_in = w2;
    chk("back-to-back first", "R6", {15'h0, out_valid}, 16'h1);
    model_check(prev);
    @(negedge clk); in_valid = 0;
    chk("back-to-back second", "R6", {15'h0, out_valid}, 16'h1);
    model_check(w2);

    for (int i = 0; i < 60; i++) begin
      logic [63:0] w;
      w = {$urandom, $urandom};
      present(w);
      model_check(w);
    end

    @(negedge clk); rows_in = '1; in_valid = 1; rst = 1;
    @(negedge clk); rst = 0; in_valid = 0;
    chk("reset wins out_valid", "R8", {15'h0, out_valid}, 16'h0);
    chk("reset wins row/col", "R8", {row_par, col_par}, 16'h0);
    chk("reset wins diag", "R8", {1'b0, slash_par | bslash_par}, 16'h0);
    @(negedge clk);
    chk("after reset hold", "R8", {1'b0, slash_par | bslash_par}, 16'h0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule